// File: doc/BRIEF.md
# SPI Register-Access Frame Master

This block drives an SPI bus in mode 0 to reach the registers and buffers of an external peripheral. The host issues one command that names a 16-bit address, a 5-bit block select, a direction and a length. The block then holds chip select low for the whole access. It first shifts out a 24-bit header. After the header it either streams payload bytes taken from a host valid/ready input or returns the bytes it clocks in on a valid-strobed output.

The length comes from a 2-bit mode code that is also placed in the header. Code 0 takes the byte count from the command and lets the chip-select window mark the end of the burst. Codes 1, 2 and 3 fix the payload at 1, 2 and 4 bytes. A single-register access is a burst of one byte with the same header. The SCLK half period is a fixed number of system clocks, set by a parameter.

Top module: `spi_frame_master`

## Requirements
- R1: The first three bytes of every frame are, in order: address bits 15..8, address bits 7..0, then a control byte laid out as {block[4:0], rw, mode[1:0]} (block in bits 7..3, rw in bit 2, mode in bits 1..0). Every byte is sent MSB first.
- R2: The rw bit in the control byte is 1 for a write command and 0 for a read command.
- R3: The payload length is cmd_len bytes for mode 0, and 1, 2 or 4 bytes for modes 1, 2 or 3. In modes 1 to 3, cmd_len is ignored. A frame has exactly 8 × (3 + length) SCLK rising edges.
- R4: A write sends its payload bytes in the order they are accepted on the write stream. A byte is accepted in a cycle where wr_valid and wr_ready are both high.
- R5: During the payload of a read, MOSI is 0. Each received byte appears on rd_data with a one-cycle rd_valid pulse, in arrival order, and rd_valid pulses only while chip select is low.
- R6: cs_n goes low before the first SCLK edge of a frame and goes high only after the last one. SCLK is low whenever cs_n is high.
- R7: Data is sampled on the SCLK rising edge and changed on the falling edge. MOSI never changes while SCLK is high.
- R8: busy is high from command acceptance until cs_n has been high for exactly one SCLK period (2 × CLK_DIV clocks). A command presented while busy is ignored and starts no frame. cs_n falls only in the cycle after a command was presented.
- R9: If the write stream has no byte ready at a byte boundary, SCLK holds low with cs_n low until a byte arrives. The frame then continues unchanged.
- R10: After reset, cs_n is 1, SCLK is 0, MOSI is 0, busy is 0 and rd_valid is 0.
- R11: Mode 0 with cmd_len of 0 sends only the 24-bit header under one chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_addr | input | 16 | Register address |
| cmd_block | input | 5 | Block select |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_mode | input | 2 | Length mode code |
| cmd_len | input | LEN_W | Payload byte count for mode 0 |
| busy | output | 1 | Transaction in progress, including the chip-select recovery time |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Master takes the write byte this cycle |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Master data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Slave data in |

## Verification
The hardest case to reach from the ports is a write stream that runs dry in the middle of a burst. The stall has to begin after the master has finished a byte and before it needs the next one. The bench therefore withholds one payload byte for longer than a full byte time, checks that SCLK is parked low with chip select still asserted, and then releases the byte and checks the captured frame. A second hard case is a command that arrives inside an active frame. The bench pulses cmd_valid with a different address part-way through a read, then checks that the slave model saw exactly one frame, that its header carries the original address, and that chip select stays high after the frame.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_addr,
  input  logic [4:0]       cmd_block,
  input  logic             cmd_write,
  input  logic [1:0]       cmd_mode,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int IDX_W = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_FETCH, S_END, S_GAP} state_t;

  state_t           state;
  logic [DIV_W-1:0] div_q;
  logic [15:0]      addr_q;
  logic [7:0]       ctrl_q;
  logic             write_q;
  logic [IDX_W-1:0] last_q, idx_q;
  logic [2:0]       bit_q;
  logic [7:0]       sreg, rx_q;
  logic             gap_q;
  logic [LEN_W-1:0] nbytes;

  wire tick      = (div_q == DIV_W'(CLK_DIV - 1));
  wire byte_done = (state == S_SHIFT) && tick && sclk && (bit_q == 3'd7);
  wire [IDX_W-1:0] next_idx = idx_q + 1'b1;
  wire next_data = (next_idx >= IDX_W'(3));
  wire at_last   = (idx_q == last_q);
  wire in_data   = (idx_q >= IDX_W'(3));
  wire [7:0] hdr_next = (next_idx == IDX_W'(1)) ? addr_q[7:0] : ctrl_q;

  assign busy     = (state != S_IDLE);
  assign mosi     = !cs_n && sreg[7];
  assign wr_ready = (state == S_FETCH) || (byte_done && !at_last && next_data && write_q);

  always_comb begin
    case (cmd_mode)
      2'd0:    nbytes = cmd_len;
      2'd1:    nbytes = LEN_W'(1);
      2'd2:    nbytes = LEN_W'(2);
      default: nbytes = LEN_W'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      div_q    <= '0;
      addr_q   <= '0;
      ctrl_q   <= '0;
      write_q  <= 1'b0;
      last_q   <= '0;
      idx_q    <= '0;
      bit_q    <= '0;
      sreg     <= '0;
      rx_q     <= '0;
      gap_q    <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (state == S_SHIFT || state == S_END || state == S_GAP)
        div_q <= tick ? '0 : div_q + 1'b1;
      else
        div_q <= '0;

      case (state)
        S_IDLE: if (cmd_valid) begin
          addr_q  <= cmd_addr;
          ctrl_q  <= {cmd_block, cmd_write, cmd_mode};
          write_q <= cmd_write;
          last_q  <= {1'b0, nbytes} + IDX_W'(2);
          idx_q   <= '0;
          bit_q   <= '0;
          sreg    <= cmd_addr[15:8];
          cs_n    <= 1'b0;
          state   <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            rx_q <= {rx_q[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_q != 3'd7) begin
              bit_q <= bit_q + 1'b1;
              sreg  <= {sreg[6:0], 1'b0};
            end else begin
              bit_q <= '0;
              if (in_data && !write_q) begin
                rd_data  <= rx_q;
                rd_valid <= 1'b1;
              end
              if (at_last) begin
                state <= S_END;
              end else begin
                idx_q <= next_idx;
                if (!next_data)     sreg  <= hdr_next;
                else if (!write_q)  sreg  <= '0;
                else if (wr_valid)  sreg  <= wr_data;
                else                state <= S_FETCH;
              end
            end
          end
        end
        S_FETCH: if (wr_valid) begin
          sreg  <= wr_data;
          state <= S_SHIFT;
        end
        S_END: if (tick) begin
          cs_n  <= 1'b1;
          gap_q <= 1'b0;
          state <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (gap_q) state <= S_IDLE;
          else       gap_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_gap_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);
  p_cs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(cmd_valid));
  p_rd_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_n);
  p_stall_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |-> (!sclk && !cs_n));
endmodule

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;
  localparam int CLK_DIV = 4;
  localparam int LEN_W   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [4:0] cmd_block = '0;
  logic [1:0] cmd_mode = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic busy, wr_ready, rd_valid, sclk, mosi, cs_n, miso;
  logic [7:0] wr_data = '0, rd_data;
  logic wr_valid = 1'b0;

  always #4 clk = ~clk;

  spi_frame_master #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_block(cmd_block), .cmd_write(cmd_write), .cmd_mode(cmd_mode),
    .cmd_len(cmd_len), .busy(busy), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso));

  int checks = 0, fails = 0;
  int sl_bits = 0, sl_frames = 0, rd_cnt = 0, gap_cnt = 0;
  logic [7:0] sl_rx [0:31];
  logic [7:0] rd_got [0:31];
  logic [7:0] wbuf [0:15];

  function automatic logic [7:0] rd_pat(input int j);
    return 8'(8'hC3 + j * 37);
  endfunction

  function automatic logic miso_bit(input int b);
    logic [7:0] v;
    v = rd_pat(b / 8 - 3);
    return v[7 - (b % 8)];
  endfunction

  assign miso = (!cs_n && sl_bits >= 24) ? miso_bit(sl_bits) : 1'b0;

  always @(negedge cs_n) sl_frames++;
  always @(posedge sclk) if (!cs_n) begin
    if (sl_bits / 8 < 32) sl_rx[sl_bits / 8] = {sl_rx[sl_bits / 8][6:0], mosi};
    sl_bits++;
  end
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_cnt < 32) rd_got[rd_cnt] = rd_data;
      rd_cnt++;
    end
    if (cs_n && busy) gap_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_xfer(input logic [15:0] a, input logic [4:0] b, input logic w,
                         input logic [1:0] m, input int len, input int stall_idx,
                         input bit poke);
    int n, f0;
    n = (m == 2'd0) ? len : (m == 2'd1) ? 1 : (m == 2'd2) ? 2 : 4;
    sl_bits = 0; rd_cnt = 0; gap_cnt = 0; f0 = sl_frames;
    for (int i = 0; i < 32; i++) sl_rx[i] = '0;
    @(negedge clk);
    cmd_addr = a; cmd_block = b; cmd_write = w; cmd_mode = m;
    cmd_len = LEN_W'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_addr = 16'hFFFF; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    if (w) begin
      for (int i = 0; i < n; i++) begin
        if (i == stall_idx) begin
          repeat (100) @(negedge clk);
          chk(!sclk && !cs_n && busy, "R9 parked", {sclk, cs_n, busy}, 3'b001);
        end
        wr_data = wbuf[i]; wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    chk(sl_frames - f0 == 1, "R8 one frame", sl_frames - f0, 1);
    chk(sl_bits == 8 * (3 + n), "R3 edge count", sl_bits, 8 * (3 + n));
    chk(sl_rx[0] == a[15:8], "R1 addr hi", sl_rx[0], a[15:8]);
    chk(sl_rx[1] == a[7:0], "R1 addr lo", sl_rx[1], a[7:0]);
    chk(sl_rx[2] == {b, w, m}, "R1/R2 control", sl_rx[2], {b, w, m});
    for (int i = 0; i < n; i++) begin
      if (w) chk(sl_rx[3 + i] == wbuf[i], "R4 payload", sl_rx[3 + i], wbuf[i]);
      else begin
        chk(sl_rx[3 + i] == 8'h00, "R5 mosi zero", sl_rx[3 + i], 0);
        chk(rd_got[i] == rd_pat(i), "R5 read byte", rd_got[i], rd_pat(i));
      end
    end
    chk(rd_cnt == (w ? 0 : n), "R5 read count", rd_cnt, w ? 0 : n);
    chk(gap_cnt == 2 * CLK_DIV, "R8 recovery", gap_cnt, 2 * CLK_DIV);
  endtask

  task automatic t_reset;
    chk(cs_n && !sclk && !mosi && !busy && !rd_valid, "R10 reset",
        {cs_n, sclk, mosi, busy, rd_valid}, 5'b10000);
  endtask

  task automatic t_single;
    wbuf[0] = 8'hA5;
    do_xfer(16'h1234, 5'h05, 1'b1, 2'd1, 0, -1, 1'b0);
    do_xfer(16'h0028, 5'h01, 1'b0, 2'd1, 0, -1, 1'b0);
  endtask

  task automatic t_fixed;
    wbuf[0] = 8'h3C; wbuf[1] = 8'h81;
    do_xfer(16'hBEEF, 5'h1F, 1'b1, 2'd2, 9, -1, 1'b0);   // R3 cmd_len ignored
    do_xfer(16'h8001, 5'h0A, 1'b0, 2'd3, 0, -1, 1'b0);   // R3 four bytes
  endtask

  task automatic t_var_write_stall;
    for (int i = 0; i < 5; i++) wbuf[i] = 8'(8'h11 * (i + 1) ^ 8'h5A);
    do_xfer(16'h4242, 5'h12, 1'b1, 2'd0, 5, 2, 1'b0);
  endtask

  task automatic t_var_read;
    do_xfer(16'h0F0F, 5'h03, 1'b0, 2'd0, 6, -1, 1'b0);
  endtask

  task automatic t_header_only;
    do_xfer(16'h7E01, 5'h10, 1'b1, 2'd0, 0, -1, 1'b0);   // R11
  endtask

  task automatic t_busy_ignore;
    int f0;
    do_xfer(16'h2468, 5'h07, 1'b0, 2'd2, 0, -1, 1'b1);
    f0 = sl_frames;
    repeat (50) @(negedge clk);
    chk(cs_n && !busy && sl_frames == f0, "R8 ignored cmd", sl_frames - f0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_fixed();
    t_var_write_stall();
    t_var_read();
    t_header_only();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule